// File: doc/BRIEF.md
# Register Window Occupancy Tracker

This block keeps the bookkeeping a windowed register file needs to decide when a procedure call or return may proceed in place and when the operating system must move a window to or from memory. It holds four small counters: windows free for a call (`cansave`), windows holding caller state that may be re-entered (`canrestore`), windows owned by another address space (`otherwin`) and windows already scrubbed for reuse (`cleanwin`). It also holds a six-bit trap-vector selector (`wstate`) and the current window index.

A request port accepts one of five window operations per cycle: a call step, a return step, a flush check, and the two handler completions that report that a window was written out to memory (spilled) or read back from memory (filled). Each request either updates the counters and the window index or, with every counter left untouched, raises a one-cycle trap request carrying a computed trap type. A write port lets system software load any counter, the selector or the window index. The window index is presented to software mirrored: visible value = window count − 1 − internal index.

The trap outcome is a two-state machine. State `OUT_QUIET` means no trap is pending; state `OUT_TRAP` drives the trap request. Transition `QUIET_TO_TRAP` (and `TRAP_STAYS`) is taken when the request of that cycle traps; `TRAP_TO_QUIET` (and `QUIET_STAYS`) when the request does not trap, or when there is no request.

Top module: `winctr_unit`

## Requirements
- R1: After reset, with window count N (parameter `NWIN`, default 8): `cansave`=N−2, `canrestore`=0, `otherwin`=0, `cleanwin`=N−1, `wstate`=0, visible window index = N−1 and no trap request.
- R2: Request code 0 (call step) with `cansave`=0 raises a spill trap (type bits 8:6 = 3'b010).
- R3: A call step with `cansave`≠0 and `cleanwin` equal to `canrestore` raises the clean-window trap of type 9'h024.
- R4: Otherwise a call step lowers `cansave` by one, raises `canrestore` by one and raises the visible window index by one, modulo N.
- R5: Request code 1 (return step) with `canrestore`=0 raises a fill trap (type bits 8:6 = 3'b011). Otherwise it raises `cansave`, lowers `canrestore` and lowers the visible window index by one, modulo N.
- R6: A spill or fill type is the base (9'h080 spill, 9'h0C0 fill) ORed with a selector field. With `otherwin`≠0 the field is 9'h020 plus `wstate`[5:3] shifted to bits 4:2. With `otherwin`=0 the field is `wstate`[2:0] shifted to bits 4:2.
- R7: Request code 2 (flush check) raises a spill trap typed as in R6 when `cansave`≠N−2, and otherwise changes nothing.
- R8: Request code 3 (spill done) raises `cansave`. It then lowers `otherwin` if that is nonzero, or else lowers `canrestore`.
- R9: Request code 4 (fill done) raises `canrestore` and raises `cleanwin` only while it is below N−1. It then lowers `otherwin` if that is nonzero, or else lowers `cansave`.
- R10: A write of the window index (select 5) takes the data modulo N as the new visible index.
- R11: A trap request is high for exactly the one cycle after the trapping request. No counter and no window index changes at that edge.
- R12: Write selects are 0 `cansave`, 1 `canrestore`, 2 `otherwin`, 3 `cleanwin`, 4 `wstate`. A write in the same cycle as a request is dropped. Request codes 5 to 7 change nothing and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Window operation request valid |
| req_op_i | input | 3 | Operation code (see R2–R9, R12) |
| wr_vld_i | input | 1 | Software write valid |
| wr_sel_i | input | 3 | Write target select (R10, R12) |
| wr_data_i | input | 8 | Write data |
| trap_vld_o | output | 1 | Trap request, one cycle per trapping operation |
| trap_type_o | output | 9 | Trap type of the current trap request |
| cansave_o | output | $clog2(NWIN) | Windows free for a call |
| canrestore_o | output | $clog2(NWIN) | Windows available for a return |
| otherwin_o | output | $clog2(NWIN) | Windows owned by another context |
| cleanwin_o | output | $clog2(NWIN) | Scrubbed windows |
| wstate_o | output | 6 | Trap-vector selector |
| cwp_o | output | $clog2(NWIN) | Software-visible window index |

## Verification
Every counter is brought out on a port, so a wrong update shows on the outputs at the clock edge that follows the request. A wrong choice between the trap and update paths has a lasting effect: a missed spill lets `cansave` wrap below zero, and the next flush check or call step then gives the wrong outcome. A wrong selector field shows only in `trap_type_o`, and only for the trapping cycle, so the bench compares the type on every trap and with `otherwin` both zero and nonzero.

// File: rtl/winctr_pkg.sv
package winctr_pkg;

    typedef enum logic [2:0] {
        OP_SAVE     = 3'd0,
        OP_RESTORE  = 3'd1,
        OP_FLUSHW   = 3'd2,
        OP_SAVED    = 3'd3,
        OP_RESTORED = 3'd4
    } win_op_e;

    typedef enum logic [2:0] {
        SEL_CANSAVE    = 3'd0,
        SEL_CANRESTORE = 3'd1,
        SEL_OTHERWIN   = 3'd2,
        SEL_CLEANWIN   = 3'd3,
        SEL_WSTATE     = 3'd4,
        SEL_CWP        = 3'd5
    } wr_sel_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DEC  = 2'd1,
        STEP_INC  = 2'd2
    } cwp_step_e;

    localparam int unsigned TT_W = 9;
    localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;
    localparam logic [TT_W-1:0] TT_OTHER_FLAG = 9'h020;
    localparam logic [TT_W-1:0] TT_CLEAN      = 9'h024;

    // Selector field ORed into a spill or fill base.
    function automatic logic [TT_W-1:0] vec_field(input logic other_nz,
                                                  input logic [5:0] wsel);
        logic [TT_W-1:0] f;
        if (other_nz) f = TT_OTHER_FLAG | {4'b0, wsel[5:3], 2'b00};
        else          f = {4'b0, wsel[2:0], 2'b00};
        return f;
    endfunction

endpackage

// File: rtl/winctr_decide.sv
module winctr_decide
    import winctr_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input  logic            req_vld_i,
    input  logic [2:0]      req_op_i,
    input  logic [CW-1:0]   cs_i,
    input  logic [CW-1:0]   cr_i,
    input  logic [CW-1:0]   ow_i,
    input  logic [CW-1:0]   cw_i,
    input  logic [5:0]      wstate_i,
    output logic            upd_o,
    output logic [CW-1:0]   cs_o,
    output logic [CW-1:0]   cr_o,
    output logic [CW-1:0]   ow_o,
    output logic [CW-1:0]   cw_o,
    output cwp_step_e       step_o,
    output logic            trap_o,
    output logic [TT_W-1:0] type_o
);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] FULL_FREE = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

    win_op_e         op;
    logic            ow_nz;
    logic [TT_W-1:0] field;

    assign op    = win_op_e'(req_op_i);
    assign ow_nz = (ow_i != '0);
    assign field = vec_field(ow_nz, wstate_i);

    always_comb begin
        upd_o  = 1'b0;
        trap_o = 1'b0;
        type_o = '0;
        cs_o   = cs_i;
        cr_o   = cr_i;
        ow_o   = ow_i;
        cw_o   = cw_i;
        step_o = STEP_HOLD;
        if (req_vld_i) begin
            unique case (op)
                OP_SAVE: begin
                    if (cs_i == '0) begin
                        trap_o = 1'b1;
                        type_o = TT_SPILL_BASE | field;
                    end else if (cw_i == cr_i) begin
                        trap_o = 1'b1;
                        type_o = TT_CLEAN;
                    end else begin
                        upd_o  = 1'b1;
                        cs_o   = cs_i - ONE;
                        cr_o   = cr_i + ONE;
                        step_o = STEP_DEC;
                    end
                end
                OP_RESTORE: begin
                    if (cr_i == '0) begin
                        trap_o = 1'b1;
                        type_o = TT_FILL_BASE | field;
                    end else begin
                        upd_o  = 1'b1;
                        cs_o   = cs_i + ONE;
                        cr_o   = cr_i - ONE;
                        step_o = STEP_INC;
                    end
                end
                OP_FLUSHW: begin
                    if (cs_i != FULL_FREE) begin
                        trap_o = 1'b1;
                        type_o = TT_SPILL_BASE | field;
                    end
                end
                OP_SAVED: begin
                    upd_o = 1'b1;
                    cs_o  = cs_i + ONE;
                    if (ow_nz) ow_o = ow_i - ONE;
                    else       cr_o = cr_i - ONE;
                end
                OP_RESTORED: begin
                    upd_o = 1'b1;
                    cr_o  = cr_i + ONE;
                    if (cw_i < CLEAN_MAX) cw_o = cw_i + ONE;
                    if (ow_nz) ow_o = ow_i - ONE;
                    else       cs_o = cs_i - ONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/winctr_cwp.sv
module winctr_cwp
    import winctr_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  cwp_step_e     step_i,
    input  logic          wr_en_i,
    input  logic [7:0]    wr_data_i,
    output logic [CW-1:0] cwp_vis_o
);
    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    logic [CW-1:0] idx_q;
    logic [CW-1:0] wr_red;

    assign wr_red = CW'(32'(wr_data_i) % NWIN);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else if (step_i == STEP_DEC) begin
            idx_q <= (idx_q == '0) ? LAST : idx_q - CW'(1);
        end else if (step_i == STEP_INC) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + CW'(1);
        end else if (wr_en_i) begin
            idx_q <= LAST - wr_red;
        end
    end

    assign cwp_vis_o = LAST - idx_q;
endmodule

// File: rtl/winctr_unit.sv
module winctr_unit
    import winctr_pkg::*;
#(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            req_vld_i,
    input  logic [2:0]      req_op_i,
    input  logic            wr_vld_i,
    input  logic [2:0]      wr_sel_i,
    input  logic [7:0]      wr_data_i,
    output logic            trap_vld_o,
    output logic [TT_W-1:0] trap_type_o,
    output logic [CW-1:0]   cansave_o,
    output logic [CW-1:0]   canrestore_o,
    output logic [CW-1:0]   otherwin_o,
    output logic [CW-1:0]   cleanwin_o,
    output logic [5:0]      wstate_o,
    output logic [CW-1:0]   cwp_o
);
    typedef enum logic {
        OUT_QUIET = 1'b0,
        OUT_TRAP  = 1'b1
    } out_state_e;

    out_state_e      st_q, st_d;
    logic [TT_W-1:0] type_q;

    logic [CW-1:0] cs_q, cr_q, ow_q, cw_q;
    logic [5:0]    ws_q;

    logic            upd;
    logic [CW-1:0]   cs_n, cr_n, ow_n, cw_n;
    cwp_step_e       step;
    logic            trap;
    logic [TT_W-1:0] ttype;
    logic            wr_ok;
    wr_sel_e         sel;

    assign wr_ok = wr_vld_i && !req_vld_i;
    assign sel   = wr_sel_e'(wr_sel_i);

    winctr_decide #(.NWIN(NWIN)) decide_i (
        .req_vld_i (req_vld_i),
        .req_op_i  (req_op_i),
        .cs_i      (cs_q),
        .cr_i      (cr_q),
        .ow_i      (ow_q),
        .cw_i      (cw_q),
        .wstate_i  (ws_q),
        .upd_o     (upd),
        .cs_o      (cs_n),
        .cr_o      (cr_n),
        .ow_o      (ow_n),
        .cw_o      (cw_n),
        .step_o    (step),
        .trap_o    (trap),
        .type_o    (ttype)
    );

    winctr_cwp #(.NWIN(NWIN)) cwp_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .wr_en_i   (wr_ok && (sel == SEL_CWP)),
        .wr_data_i (wr_data_i),
        .cwp_vis_o (cwp_o)
    );

    // Counter and selector registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cs_q <= CW'(NWIN - 2);
            cr_q <= '0;
            ow_q <= '0;
            cw_q <= CW'(NWIN - 1);
            ws_q <= '0;
        end else if (upd) begin
            cs_q <= cs_n;
            cr_q <= cr_n;
            ow_q <= ow_n;
            cw_q <= cw_n;
        end else if (wr_ok) begin
            unique case (sel)
                SEL_CANSAVE:    cs_q <= wr_data_i[CW-1:0];
                SEL_CANRESTORE: cr_q <= wr_data_i[CW-1:0];
                SEL_OTHERWIN:   ow_q <= wr_data_i[CW-1:0];
                SEL_CLEANWIN:   cw_q <= wr_data_i[CW-1:0];
                SEL_WSTATE:     ws_q <= wr_data_i[5:0];
                default: ;
            endcase
        end
    end

    // Outcome state: next-state choice.
    always_comb begin
        unique case (st_q)
            OUT_QUIET: st_d = trap ? OUT_TRAP : OUT_QUIET;  // QUIET_TO_TRAP / QUIET_STAYS
            OUT_TRAP:  st_d = trap ? OUT_TRAP : OUT_QUIET;  // TRAP_STAYS / TRAP_TO_QUIET
            default:   st_d = OUT_QUIET;
        endcase
    end

    // Outcome state register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q   <= OUT_QUIET;
            type_q <= '0;
        end else begin
            st_q   <= st_d;
            type_q <= trap ? ttype : '0;
        end
    end

    // Outputs.
    always_comb begin
        trap_vld_o   = (st_q == OUT_TRAP);
        trap_type_o  = type_q;
        cansave_o    = cs_q;
        canrestore_o = cr_q;
        otherwin_o   = ow_q;
        cleanwin_o   = cw_q;
        wstate_o     = ws_q;
    end
endmodule

// File: rtl/winctr_chk.sv
module winctr_chk #(
    parameter int unsigned NWIN = 8,
    localparam int unsigned CW = $clog2(NWIN)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          req_vld_i,
    input logic [2:0]    req_op_i,
    input logic          trap_vld_o,
    input logic [8:0]    trap_type_o,
    input logic [CW-1:0] cansave_o,
    input logic [CW-1:0] canrestore_o,
    input logic [CW-1:0] otherwin_o,
    input logic [CW-1:0] cleanwin_o,
    input logic [CW-1:0] cwp_o
);
    localparam logic [CW-1:0] FULL_FREE = CW'(NWIN - 2);
    localparam logic [CW-1:0] CLEAN_MAX = CW'(NWIN - 1);

    AST_SPILL_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd0 && cansave_o == '0)
        |=> (trap_vld_o && trap_type_o[8:6] == 3'b010)); // R2

    AST_CLEAN_PREEMPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd0 && cansave_o != '0 && cleanwin_o == canrestore_o)
        |=> (trap_vld_o && trap_type_o == 9'h024)); // R3

    AST_SAVE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd0 && cansave_o != '0 && cleanwin_o != canrestore_o)
        |=> (!trap_vld_o && cansave_o == CW'($past(cansave_o) - 1'b1)
             && canrestore_o == CW'($past(canrestore_o) + 1'b1))); // R4

    AST_FILL_ON_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd1 && canrestore_o == '0)
        |=> (trap_vld_o && trap_type_o[8:6] == 3'b011)); // R5

    AST_FLUSH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd2 && cansave_o == FULL_FREE)
        |=> !trap_vld_o); // R7

    AST_CLEANWIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_vld_i && req_op_i == 3'd4 && cleanwin_o == CLEAN_MAX)
        |=> cleanwin_o == CLEAN_MAX); // R9

    AST_TRAP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_vld_o |-> ($stable(cansave_o) && $stable(canrestore_o) && $stable(otherwin_o)
                        && $stable(cleanwin_o) && $stable(cwp_o))); // R11

    AST_TRAP_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_vld_o |-> $past(req_vld_i)); // R11
endmodule

bind winctr_unit winctr_chk #(.NWIN(NWIN)) chk_i (.*);

// File: tb/winctr_unit_tb_top.sv
module winctr_unit_tb_top;
    localparam int unsigned NWIN = 8;
    localparam int unsigned CW = $clog2(NWIN);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_vld = 1'b0;
    logic [2:0]    req_op = '0;
    logic          wr_vld = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [7:0]    wr_data = '0;
    logic          trap_vld;
    logic [8:0]    trap_type;
    logic [CW-1:0] cs, cr, ow, cw, cwp;
    logic [5:0]    ws;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    winctr_unit #(.NWIN(NWIN)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_vld_i(req_vld), .req_op_i(req_op),
        .wr_vld_i(wr_vld), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .trap_vld_o(trap_vld), .trap_type_o(trap_type),
        .cansave_o(cs), .canrestore_o(cr), .otherwin_o(ow), .cleanwin_o(cw),
        .wstate_o(ws), .cwp_o(cwp)
    );

    typedef struct packed {
        logic [2:0] op;
        logic       trap;
        logic [8:0] ttype;
        logic [2:0] cs, cr, ow, cw, cwp;
    } vec_t;

    // Starts after reset with wstate = 6'h2B (field 3 when otherwin = 0).
    localparam vec_t VECS [11] = '{
        '{3'd1, 1'b1, 9'h0CC, 3'd6, 3'd0, 3'd0, 3'd7, 3'd7}, // R5 R6 fill
        '{3'd0, 1'b0, 9'h000, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0}, // R4 wrap to 0
        '{3'd0, 1'b0, 9'h000, 3'd4, 3'd2, 3'd0, 3'd7, 3'd1}, // R4
        '{3'd2, 1'b1, 9'h08C, 3'd4, 3'd2, 3'd0, 3'd7, 3'd1}, // R7 spill
        '{3'd3, 1'b0, 9'h000, 3'd5, 3'd1, 3'd0, 3'd7, 3'd1}, // R8
        '{3'd1, 1'b0, 9'h000, 3'd6, 3'd0, 3'd0, 3'd7, 3'd0}, // R5
        '{3'd4, 1'b0, 9'h000, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0}, // R9 capped
        '{3'd2, 1'b1, 9'h08C, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0}, // R7
        '{3'd5, 1'b0, 9'h000, 3'd5, 3'd1, 3'd0, 3'd7, 3'd0}, // R12 unused code
        '{3'd3, 1'b0, 9'h000, 3'd6, 3'd0, 3'd0, 3'd7, 3'd0}, // R8
        '{3'd2, 1'b0, 9'h000, 3'd6, 3'd0, 3'd0, 3'd7, 3'd0}  // R7 no trap
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic t, input logic [8:0] tt,
                             input int e_cs, input int e_cr, input int e_ow,
                             input int e_cw, input int e_cwp);
        chk(req, "trap_vld", 32'(trap_vld), 32'(t));
        if (t) chk(req, "trap_type", 32'(trap_type), 32'(tt));
        chk(req, "cansave", 32'(cs), 32'(e_cs));
        chk(req, "canrestore", 32'(cr), 32'(e_cr));
        chk(req, "otherwin", 32'(ow), 32'(e_ow));
        chk(req, "cleanwin", 32'(cw), 32'(e_cw));
        chk(req, "cwp", 32'(cwp), 32'(e_cwp));
    endtask

    task automatic do_op(input logic [2:0] op);
        @(negedge clk);
        req_vld = 1'b1; req_op = op;
        @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic do_wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_vld = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk_state("R1", 1'b0, 9'h0, 6, 0, 0, 7, 7);
        chk("R1", "wstate", 32'(ws), 32'h0);

        do_wr(3'd4, 8'h2B);
        chk("R12", "wstate write", 32'(ws), 32'h2B);

        for (int i = 0; i < 11; i++) begin
            do_op(VECS[i].op);
            chk_state($sformatf("R6 vec%0d", i), VECS[i].trap, VECS[i].ttype,
                      VECS[i].cs, VECS[i].cr, VECS[i].ow, VECS[i].cw, VECS[i].cwp);
        end

        // R3 clean-window trap pre-empts the call step
        do_wr(3'd3, 8'd2);
        do_op(3'd0); chk_state("R4", 1'b0, 9'h0, 5, 1, 0, 2, 1);
        do_op(3'd0); chk_state("R4", 1'b0, 9'h0, 4, 2, 0, 2, 2);
        do_op(3'd0); chk_state("R3", 1'b1, 9'h024, 4, 2, 0, 2, 2);
        @(negedge clk);
        chk("R11", "pulse ends", 32'(trap_vld), 32'h0);

        // R9 cleanwin grows below the cap
        do_op(3'd4); chk_state("R9", 1'b0, 9'h0, 3, 3, 0, 3, 2);

        // R8 / R9 charge otherwin first
        do_wr(3'd2, 8'd2);
        do_op(3'd3); chk_state("R8", 1'b0, 9'h0, 4, 3, 1, 3, 2);
        do_op(3'd4); chk_state("R9", 1'b0, 9'h0, 4, 4, 0, 4, 2);

        // R6 other-context trap types
        do_wr(3'd2, 8'd1);
        do_op(3'd2); chk_state("R6", 1'b1, 9'h0B4, 4, 4, 1, 4, 2);
        do_wr(3'd1, 8'd0);
        do_op(3'd1); chk_state("R6", 1'b1, 9'h0F4, 4, 0, 1, 4, 2);
        do_wr(3'd0, 8'd0);
        do_op(3'd0); chk_state("R2", 1'b1, 9'h0B4, 0, 0, 1, 4, 2);

        // R9 cap at N-1
        do_wr(3'd3, 8'd7); do_wr(3'd2, 8'd0); do_wr(3'd0, 8'd2); do_wr(3'd1, 8'd1);
        do_op(3'd4); chk_state("R9", 1'b0, 9'h0, 1, 2, 0, 7, 2);

        // R10 window index writes reduce modulo N
        do_wr(3'd5, 8'd11);  chk("R10", "cwp 11", 32'(cwp), 32'd3);
        do_wr(3'd5, 8'd255); chk("R10", "cwp 255", 32'(cwp), 32'd7);

        // R4 / R5 wrap of the visible index
        do_wr(3'd0, 8'd3); do_wr(3'd1, 8'd0);
        do_op(3'd0); chk_state("R4", 1'b0, 9'h0, 2, 1, 0, 7, 0);
        do_op(3'd1); chk_state("R5", 1'b0, 9'h0, 3, 0, 0, 7, 7);

        // R12 request wins over a write in the same cycle
        @(negedge clk);
        req_vld = 1'b1; req_op = 3'd0;
        wr_vld = 1'b1; wr_sel = 3'd0; wr_data = 8'd1;
        @(negedge clk);
        req_vld = 1'b0; wr_vld = 1'b0;
        chk_state("R12", 1'b0, 9'h0, 2, 1, 0, 7, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule